// File: doc/BRIEF.md
# Configuration Register Target for a Serial Two-Wire Bus

This block is the serial control port of a clock generator. It is an I2C target that holds six 8-bit configuration bytes. The target runs on a fast system clock. It synchronises and deglitches SCL and SDA, finds START and STOP conditions, and matches a 7-bit device address. It acknowledges bytes and pulls SDA low through an output enable. The enable is meant for an open-drain pad, so a 1 means the line is driven low.

Writes follow the block-write shape. After the address come two bytes that are acknowledged and thrown away. The rest of the bytes fill the registers from index 0 upward, and a STOP may end the write after any byte. A read has no command phase. The target first returns a count of 6 and then returns registers 0 to 5.

At reset, the four frequency-select strap pins are latched. Register 4 picks where the frequency code comes from: the latched straps or a programmed value. Two of the readback bytes carry read-only content in place of the stored bits: a revision number in register 4 and the latched straps in register 5.

Top module: `cfg_i2c_target`

## Requirements
- R1: While `rst_n` is low, `cfg_o` takes the value of `REG_DEFAULTS`, with register i in bits [8i+7:8i] (default: registers 0-3 = 0xFF, registers 4-5 = 0x00). `sda_oe` is 0 and the strap pins are latched.
- R2: The target acknowledges the address byte 0xD2 (write) and 0xD3 (read). For any other address it does not acknowledge and ignores the bus until the next START.
- R3: In a write, the two bytes that follow the address are acknowledged and have no effect. Each later byte is acknowledged and stored into the next register, starting at register 0.
- R4: A STOP after any complete byte ends loading. Registers not reached keep their earlier values.
- R5: Write bytes beyond register 5 are acknowledged and discarded.
- R6: A read returns 0x06 first, then registers 0 to 5 in order, MSB first. The target advances to the next byte only after the host acknowledges.
- R7: A readback of register 4 shows revision bits REV_ID[4:1] in bits 7:4 and REV_ID[0] in bit 2 (default REV_ID = 0x13, so 1001 and 1). Bits 3, 1 and 0 show the stored value.
- R8: A readback of register 5 shows the strap pins as latched at reset in bits 3:0. Later changes on `fs_strap_i` have no effect.
- R9: `freq_code_o` equals register 4 bits 7:4 when register 4 bit 3 is 1. Otherwise it equals the latched straps.
- R10: After the host fails to acknowledge a read byte, the target releases SDA and sends nothing more until a START or STOP.
- R11: An SDA pulse shorter than FILT_LEN (3) system clocks while SCL is high is not taken as START or STOP.
- R12: A repeated START in the middle of a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 40x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset; straps latched while low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| fs_strap_i | input | 4 | Frequency-select strap pins |
| cfg_o | output | 48 | Stored configuration registers, register i in bits [8i+7:8i] |
| freq_code_o | output | 4 | Selected frequency code |

## Verification
A wrong byte counter makes data land in the wrong register. That error shows on `cfg_o` within a few system clocks after the SCL fall that ends the byte. During a read, the same fault shows on SDA one byte later.

A bad protocol state shows up during the acknowledge clock, when `sda_oe` is missing or asserted when it should not be. A wrong read byte shows as a bit error on SDA during the next byte sent.

A strap or revision overlay that is missing or misplaced can only be seen through a full read, in byte 5 or byte 6 of the reply.

// File: rtl/cfg_i2c_pkg.sv
// Shared constants and the protocol state type of the configuration target.
// Assumes at least six registers, since registers 4 and 5 carry fixed meanings.
package cfg_i2c_pkg;
    localparam int FREQ_IDX  = 4;   // register holding source select and code
    localparam int STRAP_IDX = 5;   // register whose low nibble reads the straps

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_RECV, ST_SEND, ST_HACK, ST_WAIT
    } proto_st_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Two-flop synchroniser followed by a persistence filter for one bus line.
// The output follows the input only after the synchronised value has differed
// from it for FILT_LEN consecutive clocks. Idle level after reset is 1.
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // accept a new level only after it has persisted long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o <= 1'b1;
            run_q  <= '0;
        end else if (sync_q[1] != filt_o) begin
            if (run_q == CW'(FILT_LEN - 1)) begin
                filt_o <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end
endmodule

// File: rtl/cfg_regbank.sv
// Configuration register bank with power-on defaults, a strap latch and the
// readback overlay. A write is a one-cycle strobe with an in-range index.
// Straps are sampled on every clock while reset is held low.
module cfg_regbank #(
    parameter int                    NUM_REGS = 6,
    parameter logic [4:0]            REV_ID   = 5'h13,
    parameter logic [8*NUM_REGS-1:0] DEFAULTS = '0,
    localparam int                   IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            fs_strap_i,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [8*NUM_REGS-1:0] cfg_o,
    output logic [3:0]            freq_code_o
);
    import cfg_i2c_pkg::*;

    logic [8*NUM_REGS-1:0] cfg_q;
    logic [3:0]            fs_q;

    // register storage: defaults in reset, byte writes afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= DEFAULTS;
        else if (wr_en) cfg_q[8*wr_idx +: 8] <= wr_data;
    end

    // strap latch: follows the pins only while reset is asserted
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= fs_strap_i;
    end

    // readback byte with revision and strap overlays
    always_comb begin
        rd_data = (32'(rd_idx) < NUM_REGS) ? cfg_q[8*rd_idx +: 8] : 8'h00;
        if (32'(rd_idx) == FREQ_IDX) begin
            rd_data[7:4] = REV_ID[4:1];
            rd_data[2]   = REV_ID[0];
        end
        if (32'(rd_idx) == STRAP_IDX) rd_data[3:0] = fs_q;
    end

    assign cfg_o       = cfg_q;
    assign freq_code_o = cfg_q[8*FREQ_IDX+3] ? cfg_q[8*FREQ_IDX+4 +: 4] : fs_q;
endmodule

// File: rtl/cfg_i2c_target.sv
// Two-wire bus target for a clock generator's configuration bytes.
// Write: address, two ignored bytes, then data from register 0 upward.
// Read: a count byte, then registers 0 up. Assumes clk >= 40x the SCL rate
// and an open-drain pad driven from sda_oe.
module cfg_i2c_target #(
    parameter int                    NUM_REGS     = 6,
    parameter logic [6:0]            DEV_ADDR     = 7'h69,
    parameter int                    FILT_LEN     = 3,
    parameter logic [4:0]            REV_ID       = 5'h13,
    parameter logic [8*NUM_REGS-1:0] REG_DEFAULTS = 48'h0000_FFFF_FFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [3:0]            fs_strap_i,
    output logic [8*NUM_REGS-1:0] cfg_o,
    output logic [3:0]            freq_code_o
);
    import cfg_i2c_pkg::*;

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int CNT_W = $clog2(NUM_REGS + 3);

    logic [1:0] raw_w, filt_w;
    logic       scl_f, sda_f, scl_d, sda_d;
    logic       start_ev, stop_ev, scl_rise, scl_fall;

    proto_st_t        state;
    logic [3:0]       bitcnt;
    logic [7:0]       sh, tx;
    logic             is_rd, host_ack, oe;
    logic [CNT_W-1:0] cnt, next_rd_cnt;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       rd_data, load_byte;

    assign raw_w = {scl_i, sda_i};

    // one filter per bus line
    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_w[g]), .filt_o(filt_w[g]));
    end
    assign scl_f = filt_w[1];
    assign sda_f = filt_w[0];

    // previous filtered levels for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;

    // write strobe for data bytes that fall inside the bank
    assign wr_en  = (state == ST_RECV) && scl_fall && (bitcnt == 4'd8)
                    && (cnt >= CNT_W'(2)) && (cnt < CNT_W'(NUM_REGS + 2));
    assign wr_idx = IDX_W'(cnt - CNT_W'(2));

    // read position of the byte to be loaded next (0 = count byte)
    always_comb begin
        next_rd_cnt = cnt;
        if (state == ST_HACK && cnt != '1) next_rd_cnt = cnt + 1'b1;
        rd_idx = IDX_W'(next_rd_cnt - 1'b1);
        if (next_rd_cnt == '0)                        load_byte = 8'(NUM_REGS);
        else if (next_rd_cnt <= CNT_W'(NUM_REGS))     load_byte = rd_data;
        else                                          load_byte = 8'hFF;
    end

    // protocol sequencer: address match, acknowledge, receive and send
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; bitcnt <= '0; sh <= '0; tx <= '0;
            is_rd <= 1'b0; host_ack <= 1'b0; oe <= 1'b0; cnt <= '0;
        end else if (start_ev) begin
            state <= ST_ADDR; bitcnt <= '0; oe <= 1'b0; cnt <= '0;
        end else if (stop_ev) begin
            state <= ST_IDLE; oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_RECV: begin
                    if (scl_rise) begin
                        sh     <= {sh[6:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                is_rd <= sh[0];
                                oe    <= 1'b1;
                                state <= ST_ACK;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else begin
                            oe    <= 1'b1;
                            state <= ST_ACK;
                            if (cnt != '1) cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ACK: if (scl_fall) begin
                    if (is_rd) begin
                        tx    <= load_byte;
                        oe    <= ~load_byte[7];
                        state <= ST_SEND;
                    end else begin
                        oe    <= 1'b0;
                        state <= ST_RECV;
                    end
                end
                ST_SEND: if (scl_fall) begin
                    if (bitcnt == 4'd7) begin
                        oe     <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_HACK;
                    end else begin
                        oe     <= ~tx[6];
                        tx     <= {tx[6:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_HACK: begin
                    if (scl_rise) host_ack <= ~sda_f;
                    else if (scl_fall) begin
                        if (host_ack) begin
                            cnt   <= next_rd_cnt;
                            tx    <= load_byte;
                            oe    <= ~load_byte[7];
                            state <= ST_SEND;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe;

    cfg_regbank #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID), .DEFAULTS(REG_DEFAULTS)) u_bank (
        .clk(clk), .rst_n(rst_n), .fs_strap_i(fs_strap_i),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(sh),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .cfg_o(cfg_o), .freq_code_o(freq_code_o));
endmodule

// File: rtl/cfg_i2c_target_chk.sv
// Port-level checker for cfg_i2c_target, attached by bind.
// Assumes SCL stays low for longer than the filter latency after each fall.
module cfg_i2c_target_chk #(
    parameter int CFG_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic [CFG_W-1:0] cfg_o,
    input logic [3:0]       freq_code_o
);
    // R1
    reset_release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe);

    // R2
    oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R3
    cfg_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> !scl_i);

    // R9
    freq_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_code_o) |-> !$stable(cfg_o));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.CFG_W(8*NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .cfg_o(cfg_o), .freq_code_o(freq_code_o));

// File: tb/sim_cfg_i2c_target.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_cfg_i2c_target;
    localparam int Q = 25;   // system clocks per quarter bit

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        drv_low = 1'b0;
    logic [3:0]  straps = 4'hA;
    logic        sda_oe;
    logic [47:0] cfg;
    logic [3:0]  fcode;
    wire         sda_bus = ~(drv_low | sda_oe);

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cfg_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .fs_strap_i(straps), .cfg_o(cfg), .freq_code_o(fcode));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        drv_low = 1'b0; wq(); scl = 1'b1; wq(); drv_low = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        drv_low = 1'b1; wq(); scl = 1'b1; wq(); drv_low = 1'b0; wq();
    endtask

    task automatic wbit(input logic b, input logic glitch);
        drv_low = ~b; wq(); scl = 1'b1; wq();
        if (glitch) begin
            drv_low = 1'b1; repeat (2) @(negedge clk); drv_low = ~b;
        end
        wq(); scl = 1'b0; wq();
    endtask

    task automatic rbit(output logic b);
        drv_low = 1'b0; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, input logic glitch_msb, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) wbit(d[i], glitch_msb && i == 7);
        rbit(s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) rbit(d[i]);
        wbit(~host_ack, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 cfg defaults", 64'(cfg), 64'h0000_FFFF_FFFF);
        chk("R1 sda released", 64'(sda_oe), 64'd0);
        chk("R9 straps select code", 64'(fcode), 64'hA);
    endtask

    task automatic t_full_write();
        logic a;
        logic [7:0] dat [7] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hC8, 8'h5E, 8'h77};
        bus_start();
        send_byte(8'hD2, 1'b0, a); chk("R2 write address ack", 64'(a), 64'd1);
        send_byte(8'h55, 1'b0, a); chk("R3 command ack", 64'(a), 64'd1);
        send_byte(8'h99, 1'b0, a); chk("R3 count ack", 64'(a), 64'd1);
        for (int i = 0; i < 6; i++) begin
            send_byte(dat[i], 1'b0, a); chk("R3 data ack", 64'(a), 64'd1);
        end
        chk("R3 registers loaded", 64'(cfg), 64'h5EC8_4433_2211);
        send_byte(dat[6], 1'b0, a); chk("R5 extra byte ack", 64'(a), 64'd1);
        chk("R5 extra byte discarded", 64'(cfg), 64'h5EC8_4433_2211);
        bus_stop();
        chk("R9 programmed code", 64'(fcode), 64'hC);
    endtask

    task automatic t_read_all();
        logic a;
        logic [7:0] d;
        logic [7:0] exp [7] = '{8'h06, 8'h11, 8'h22, 8'h33, 8'h44, 8'h9C, 8'h5A};
        bus_start();
        send_byte(8'hD3, 1'b0, a); chk("R2 read address ack", 64'(a), 64'd1);
        for (int i = 0; i < 7; i++) begin
            recv_byte(i != 6, d);
            if (i == 5)      chk("R7 revision overlay", 64'(d), 64'(exp[i]));
            else if (i == 6) chk("R8 strap readback", 64'(d), 64'(exp[i]));
            else             chk("R6 read sequence", 64'(d), 64'(exp[i]));
        end
        bus_stop();
    endtask

    task automatic t_partial();
        logic a;
        bus_start();
        send_byte(8'hD2, 1'b0, a); send_byte(8'h01, 1'b0, a); send_byte(8'h02, 1'b0, a);
        send_byte(8'hAA, 1'b0, a); send_byte(8'hBB, 1'b0, a);
        bus_stop();
        chk("R4 partial write", 64'(cfg), 64'h5EC8_4433_BBAA);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'hA4, 1'b0, a); chk("R2 foreign address nack", 64'(a), 64'd0);
        send_byte(8'h00, 1'b0, a); chk("R2 ignored after nack", 64'(a), 64'd0);
        send_byte(8'h00, 1'b0, a);
        bus_stop();
        chk("R2 no register change", 64'(cfg), 64'h5EC8_4433_BBAA);
    endtask

    task automatic t_strap_source();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, 1'b0, a); send_byte(8'h00, 1'b0, a); send_byte(8'h00, 1'b0, a);
        send_byte(8'hAA, 1'b0, a); send_byte(8'hBB, 1'b0, a);
        send_byte(8'h33, 1'b0, a); send_byte(8'h44, 1'b0, a); send_byte(8'h70, 1'b0, a);
        bus_stop();
        chk("R9 strap source again", 64'(fcode), 64'hA);
        straps = 4'h5;
        repeat (10) @(negedge clk);
        chk("R8 pins after reset ignored", 64'(fcode), 64'hA);
        bus_start();
        send_byte(8'hD3, 1'b0, a);
        for (int i = 0; i < 7; i++) recv_byte(i != 6, d);
        chk("R8 strap nibble kept", 64'(d), 64'h5A);
        bus_stop();
    endtask

    task automatic t_host_nack();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD3, 1'b0, a);
        recv_byte(1'b1, d); chk("R6 count byte", 64'(d), 64'h06);
        recv_byte(1'b0, d); chk("R6 register 0", 64'(d), 64'hAA);
        recv_byte(1'b0, d); chk("R10 released after nack", 64'(d), 64'hFF);
        bus_stop();
    endtask

    task automatic t_repeated_start();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, 1'b0, a); send_byte(8'h00, 1'b0, a);
        bus_start();
        send_byte(8'hD3, 1'b0, a); chk("R12 address after restart", 64'(a), 64'd1);
        recv_byte(1'b0, d); chk("R12 count after restart", 64'(d), 64'h06);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic a;
        bus_start();
        send_byte(8'hD2, 1'b0, a); send_byte(8'h00, 1'b0, a); send_byte(8'h00, 1'b0, a);
        send_byte(8'hF0, 1'b1, a); chk("R11 glitched byte ack", 64'(a), 64'd1);
        bus_stop();
        chk("R11 glitched byte stored", 64'(cfg[7:0]), 64'hF0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_full_write();
        t_read_all();
        t_partial();
        t_bad_addr();
        t_strap_source();
        t_host_nack();
        t_repeated_start();
        t_glitch();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule